// File: doc/BRIEF.md
# Three-Step Instruction Control Sequencer

This block is the control unit of a small multicycle processor with 8-bit instructions. Each instruction takes three steps: fetch, read/execute and write-back. The block steps through them in a fixed loop. In each step it drives the datapath control lines from the current step and the 4-bit operation code of the instruction. The datapath itself (register file, ALU, memories, program counter) lies outside the block. It only consumes the control lines.

The operation code comes straight from the instruction memory output. The block captures that code on the clock edge that ends the fetch step. The execute and write-back steps then decode the captured copy, so the control lines stay steady even if the memory output moves on. All control outputs are combinational functions of the step register and the captured code. While reset is asserted they are forced low.

Top module: `step_ctrl_top`

## Requirements
- R1: While `rst_n` is low, `step_o` reads 0 (fetch) and every control output is 0.
- R2: After reset, `step_o` cycles 0 (fetch), 1 (execute), 2 (write-back), then 0 again. It advances one step per rising clock edge.
- R3: In fetch, `fetch_en` and `mem_rd` are 1 and every other control output is 0, whatever the operation code.
- R4: Codes 0 (branch if zero) and 1 (branch if greater than zero) raise `reg_rd` and `branch_en` in execute. `br_gt_sel` is 1 for code 1 and 0 for code 0. Nothing is raised in write-back.
- R5: Code 2 (shift left) raises `reg_rd` and `alu_b_sel` in execute. Codes 3 to 7 (add, subtract, invert, and, or) raise only `reg_rd` in execute. All six raise only `reg_wr` in write-back.
- R6: Code 8 (load) raises only `mem_rd` in execute and only `reg_wr` in write-back. Code 9 (store) raises `reg_rd` and `mem_wr` in execute and nothing in write-back.
- R7: Code 10 (set memory register from a register) raises `reg_rd`, `mreg_set` and `mreg_src` in execute. Code 11 (set memory register from the immediate) raises only `mreg_set`. Neither raises anything in write-back.
- R8: Code 12 (add immediate) raises `reg_rd`, `imp_r3`, `imm4` and `alu_b_sel` in execute, and only `reg_wr` in write-back.
- R9: Code 13 (load immediate) raises nothing in execute and `reg_wr`, `imp_r3` and `imm_data` in write-back. Code 14 (clear) raises nothing in execute and `reg_wr` and `wr_zero` in write-back.
- R10: Code 15 is unassigned and raises nothing in execute or write-back.
- R11: The code decoded in execute and write-back is the value `opcode` had at the edge that ended fetch. Changes on `opcode` during execute and write-back have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Operation code from the instruction memory output |
| step_o | output | 2 | Current step: 0 fetch, 1 execute, 2 write-back |
| fetch_en | output | 1 | Instruction fetch enable |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| reg_rd | output | 1 | Register file read |
| reg_wr | output | 1 | Register file write |
| branch_en | output | 1 | Branch evaluation enable |
| br_gt_sel | output | 1 | Branch condition select: 1 greater-than-zero, 0 equal-zero |
| alu_b_sel | output | 1 | Second ALU operand select |
| mreg_set | output | 1 | Load the memory access register |
| mreg_src | output | 1 | Memory access register source select |
| imp_r3 | output | 1 | Route register 3 as the implicit operand |
| imm_data | output | 1 | Write-back data taken from the immediate |
| imm4 | output | 1 | Second operand taken from the 4-bit immediate |
| wr_zero | output | 1 | Write-back data forced to zero |

## Verification
All sixteen codes are first held steady across complete instructions. This separates the control set of every instruction in both later steps, and it shows that branch-if-zero differs from branch-if-greater only in the condition select. The code is then changed on every cycle. If the decoder reads the live input rather than the copy captured at the end of fetch, the outputs show it here. Finally, reset is asserted in the middle of an instruction. This confirms that the outputs drop at once and that the loop restarts cleanly from fetch.

// File: rtl/step_ctrl_pkg.sv
package step_ctrl_pkg;

  localparam int OP_W   = 4;
  localparam int STEP_W = 2;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_WB    = 2'd2,
    ST_BAD   = 2'd3
  } step_e;

  typedef enum logic [OP_W-1:0] {
    OP_BRZ   = 4'd0,
    OP_BRGT  = 4'd1,
    OP_SHL   = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_INV   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_LD    = 4'd8,
    OP_ST    = 4'd9,
    OP_MRR   = 4'd10,
    OP_MRI   = 4'd11,
    OP_ADDI  = 4'd12,
    OP_LDI   = 4'd13,
    OP_CLR   = 4'd14,
    OP_NONE  = 4'd15
  } op_e;

  typedef struct packed {
    logic fetch_en;
    logic mem_rd;
    logic mem_wr;
    logic reg_rd;
    logic reg_wr;
    logic branch_en;
    logic br_gt_sel;
    logic alu_b_sel;
    logic mreg_set;
    logic mreg_src;
    logic imp_r3;
    logic imm_data;
    logic imm4;
    logic wr_zero;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/step_ctrl_seq.sv
module step_ctrl_seq
  import step_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output step_e step_q
);

  step_e step_d;

  always_comb begin
    unique case (step_q)
      ST_FETCH: step_d = ST_EXEC;
      ST_EXEC:  step_d = ST_WB;
      default:  step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

endmodule

// File: rtl/step_ctrl_oplatch.sv
module step_ctrl_oplatch
  import step_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  step_e           step_q,
  input  logic [OP_W-1:0] op_in,
  output op_e             op_q
);

  // capture on the edge that closes fetch; hold for the rest of the instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 op_q <= OP_NONE;
    else if (step_q == ST_FETCH) op_q <= op_e'(op_in);
  end

endmodule

// File: rtl/step_ctrl_dec.sv
module step_ctrl_dec
  import step_ctrl_pkg::*;
(
  input  step_e step_q,
  input  op_e   op_q,
  output ctrl_t ctrl
);

  ctrl_t ex_c;
  ctrl_t wb_c;

  // execute-step control set
  always_comb begin
    ex_c = '0;
    unique case (op_q)
      OP_BRZ, OP_BRGT: begin
        ex_c.reg_rd    = 1'b1;
        ex_c.branch_en = 1'b1;
        ex_c.br_gt_sel = (op_q == OP_BRGT);
      end
      OP_SHL: begin
        ex_c.reg_rd    = 1'b1;
        ex_c.alu_b_sel = 1'b1;
      end
      OP_ADD, OP_SUB, OP_INV, OP_AND, OP_OR: ex_c.reg_rd = 1'b1;
      OP_LD:  ex_c.mem_rd = 1'b1;
      OP_ST: begin
        ex_c.reg_rd = 1'b1;
        ex_c.mem_wr = 1'b1;
      end
      OP_MRR: begin
        ex_c.reg_rd   = 1'b1;
        ex_c.mreg_set = 1'b1;
        ex_c.mreg_src = 1'b1;
      end
      OP_MRI: ex_c.mreg_set = 1'b1;
      OP_ADDI: begin
        ex_c.reg_rd    = 1'b1;
        ex_c.imp_r3    = 1'b1;
        ex_c.imm4      = 1'b1;
        ex_c.alu_b_sel = 1'b1;
      end
      default: ex_c = '0;
    endcase
  end

  // write-back-step control set
  always_comb begin
    wb_c = '0;
    unique case (op_q)
      OP_SHL, OP_ADD, OP_SUB, OP_INV, OP_AND, OP_OR, OP_LD, OP_ADDI:
        wb_c.reg_wr = 1'b1;
      OP_LDI: begin
        wb_c.reg_wr   = 1'b1;
        wb_c.imp_r3   = 1'b1;
        wb_c.imm_data = 1'b1;
      end
      OP_CLR: begin
        wb_c.reg_wr  = 1'b1;
        wb_c.wr_zero = 1'b1;
      end
      default: wb_c = '0;
    endcase
  end

  always_comb begin
    ctrl = '0;
    unique case (step_q)
      ST_FETCH: begin
        ctrl.fetch_en = 1'b1;
        ctrl.mem_rd   = 1'b1;
      end
      ST_EXEC: ctrl = ex_c;
      ST_WB:   ctrl = wb_c;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/step_ctrl_top.sv
module step_ctrl_top
  import step_ctrl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [step_ctrl_pkg::OP_W-1:0]   opcode,
  output logic [step_ctrl_pkg::STEP_W-1:0] step_o,
  output logic                        fetch_en,
  output logic                        mem_rd,
  output logic                        mem_wr,
  output logic                        reg_rd,
  output logic                        reg_wr,
  output logic                        branch_en,
  output logic                        br_gt_sel,
  output logic                        alu_b_sel,
  output logic                        mreg_set,
  output logic                        mreg_src,
  output logic                        imp_r3,
  output logic                        imm_data,
  output logic                        imm4,
  output logic                        wr_zero
);

  step_e step_q;
  op_e   op_q;
  ctrl_t dec_c;
  ctrl_t out_c;

  step_ctrl_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_q (step_q)
  );

  step_ctrl_oplatch u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_q (step_q),
    .op_in  (opcode),
    .op_q   (op_q)
  );

  step_ctrl_dec u_dec (
    .step_q (step_q),
    .op_q   (op_q),
    .ctrl   (dec_c)
  );

  assign out_c = rst_n ? dec_c : '0;

  assign step_o    = step_q;
  assign fetch_en  = out_c.fetch_en;
  assign mem_rd    = out_c.mem_rd;
  assign mem_wr    = out_c.mem_wr;
  assign reg_rd    = out_c.reg_rd;
  assign reg_wr    = out_c.reg_wr;
  assign branch_en = out_c.branch_en;
  assign br_gt_sel = out_c.br_gt_sel;
  assign alu_b_sel = out_c.alu_b_sel;
  assign mreg_set  = out_c.mreg_set;
  assign mreg_src  = out_c.mreg_src;
  assign imp_r3    = out_c.imp_r3;
  assign imm_data  = out_c.imm_data;
  assign imm4      = out_c.imm4;
  assign wr_zero   = out_c.wr_zero;

endmodule

// File: rtl/step_ctrl_chk.sv
module step_ctrl_chk
  import step_ctrl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [STEP_W-1:0] step_o,
  input logic [OP_W-1:0] op_q,
  input logic            fetch_en,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            reg_rd,
  input logic            reg_wr,
  input logic            branch_en,
  input logic            br_gt_sel,
  input logic            mreg_set,
  input logic            mreg_src,
  input logic            wr_zero
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (step_o == 2'd0 && !fetch_en && !mem_rd && !reg_wr && !reg_rd));

  // R2
  step_fetch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o == 2'd0 |=> step_o == 2'd1);

  // R2
  step_exec_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o == 2'd1 |=> step_o == 2'd2);

  // R2
  step_wb_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o == 2'd2 |=> step_o == 2'd0);

  // R3
  fetch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o == 2'd0 |-> (fetch_en && mem_rd && !mem_wr && !reg_wr && !branch_en));

  // R4
  gt_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_gt_sel |-> (branch_en && step_o == 2'd1));

  // R6
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R7
  mreg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreg_src |-> (mreg_set && reg_rd));

  // R9
  zero_in_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_zero |-> (reg_wr && step_o == 2'd2));

  // R11
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o == 2'd1 |=> $stable(op_q));

endmodule

bind step_ctrl_top step_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_o    (step_o),
  .op_q      (op_q),
  .fetch_en  (fetch_en),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .branch_en (branch_en),
  .br_gt_sel (br_gt_sel),
  .mreg_set  (mreg_set),
  .mreg_src  (mreg_src),
  .wr_zero   (wr_zero)
);

// File: tb/sim_step_ctrl_top.sv
module sim_step_ctrl_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  // bit positions in the bench's own output vector
  localparam int B_FE = 13, B_MR = 12, B_MW = 11, B_RR = 10, B_RW = 9, B_BR = 8,
                 B_GT = 7, B_AB = 6, B_MS = 5, B_MC = 4, B_I3 = 3, B_ID = 2,
                 B_I4 = 1, B_WZ = 0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode = 4'd0;
  logic [1:0] step_o;
  logic fetch_en, mem_rd, mem_wr, reg_rd, reg_wr, branch_en, br_gt_sel;
  logic alu_b_sel, mreg_set, mreg_src, imp_r3, imm_data, imm4, wr_zero;

  int n_chk = 0;
  int n_bad = 0;
  bit live_phase = 1'b0;

  // reference model state
  int m_step = 0;
  int m_op = 15;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_ctrl_top u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .step_o(step_o),
    .fetch_en(fetch_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .branch_en(branch_en), .br_gt_sel(br_gt_sel),
    .alu_b_sel(alu_b_sel), .mreg_set(mreg_set), .mreg_src(mreg_src),
    .imp_r3(imp_r3), .imm_data(imm_data), .imm4(imm4), .wr_zero(wr_zero)
  );

  function automatic logic [13:0] bitv(input int b);
    logic [13:0] v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  function automatic logic [13:0] expect_vec(input bit rs, input int st, input int op);
    logic [13:0] v = '0;
    if (!rs) return v;
    if (st == 0) return bitv(B_FE) | bitv(B_MR);
    if (st == 1) begin
      if (op <= 1)       v = bitv(B_RR) | bitv(B_BR) | (op == 1 ? bitv(B_GT) : 14'd0);
      else if (op == 2)  v = bitv(B_RR) | bitv(B_AB);
      else if (op <= 7)  v = bitv(B_RR);
      else if (op == 8)  v = bitv(B_MR);
      else if (op == 9)  v = bitv(B_RR) | bitv(B_MW);
      else if (op == 10) v = bitv(B_RR) | bitv(B_MS) | bitv(B_MC);
      else if (op == 11) v = bitv(B_MS);
      else if (op == 12) v = bitv(B_RR) | bitv(B_I3) | bitv(B_I4) | bitv(B_AB);
    end else if (st == 2) begin
      if (op >= 2 && op <= 8) v = bitv(B_RW);
      else if (op == 12)      v = bitv(B_RW);
      else if (op == 13)      v = bitv(B_RW) | bitv(B_I3) | bitv(B_ID);
      else if (op == 14)      v = bitv(B_RW) | bitv(B_WZ);
    end
    return v;
  endfunction

  function automatic string req_of(input bit rs, input int st, input int op);
    if (!rs) return "R1";
    if (st == 0) return "R3";
    if (op <= 1)  return "R4";
    if (op <= 7)  return "R5";
    if (op <= 9)  return "R6";
    if (op <= 11) return "R7";
    if (op == 12) return "R8";
    if (op <= 14) return "R9";
    return "R10";
  endfunction

  // reference model: advances on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_step = 0;
    else begin
      if (m_step == 0) m_op = opcode;
      m_step = (m_step + 1) % 3;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    logic [13:0] act, exp_v;
    int exp_st;
    string tag;
    act = {fetch_en, mem_rd, mem_wr, reg_rd, reg_wr, branch_en, br_gt_sel,
           alu_b_sel, mreg_set, mreg_src, imp_r3, imm_data, imm4, wr_zero};
    exp_v  = expect_vec(rst_n, m_step, m_op);
    exp_st = rst_n ? m_step : 0;
    n_chk++;
    if (int'(step_o) != exp_st) begin
      n_bad++;
      $display("FAIL %s step actual=%0d expected=%0d", rst_n ? "R2" : "R1", step_o, exp_st);
    end
    n_chk++;
    tag = req_of(rst_n, m_step, m_op);
    if (act !== exp_v) begin
      n_bad++;
      // R11: during the live phase the input changes while the captured code must hold
      $display("FAIL %s%s op=%0d step=%0d ctrl actual=%b expected=%b",
               live_phase ? "R11/" : "", tag, m_op, m_step, act, exp_v);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [3:0] lfsr;
    // R1: reset held
    cycles(3);
    #1 rst_n = 1'b1;
    // R3..R10: every code held steady across full instructions
    for (int op = 0; op < 16; op++) begin
      #1 opcode = op[3:0];
      cycles(6);
    end
    // R11: code changes every cycle
    live_phase = 1'b1;
    lfsr = 4'b1011;
    for (int i = 0; i < 60; i++) begin
      #1 opcode = lfsr;
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      @(negedge clk);
    end
    live_phase = 1'b0;
    // R1, R2: reset in the middle of an instruction
    #1 opcode = 4'd12;
    cycles(4);
    #1 rst_n = 1'b0;
    cycles(2);
    #1 rst_n = 1'b1;
    opcode = 4'd13;
    cycles(9);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule